// File: doc/BRIEF.md
# Masked Message-Interrupt Dispatcher

This block keeps a message-interrupt vector table and a pending-bit array for a parameterised number of vectors. It turns per-vector interrupt request pulses from the device into message writes. Each table entry stores a 64-bit message address, a 32-bit message data word and a per-vector mask. A global enable and a function-wide mask come from a message-control word that this block owns. A request that cannot be sent because of any mask, or because the enable is off, is kept as a pending bit. It is sent later, once the vector becomes eligible.

Software reaches the table, the pending array and the control word through a simple word-addressed register port with combinational read data. Messages leave one at a time on a valid/ready channel. Eligibility is evaluated centrally every cycle. Any change to a per-vector mask, the function mask or the enable therefore replays the pending bits without help from device logic. Clearing the function mask can release a run of queued messages, which are sent lowest vector first.

Word map (N vectors): vector v uses words 4v..4v+3. The pending array follows at words 4N.., one 32-bit word per 32 vectors. The control word comes last, at 4N + ceil(N/32). With the default N = 8, the pending array is at word 32 and the control word at word 33.

Top module: `msix_dispatch`

## Requirements
- R1: After reset every vector control word reads 1 (masked), the pending array reads 0, the control word reads 0, and `msg_valid` is 0.
- R2: For vector v, word 4v+0 is the address low half, 4v+1 the address high half and 4v+2 the message data; each reads back what was written. In word 4v+3 only bit 0 (the vector mask) is stored, and all other bits read 0.
- R3: A request on a vector whose mask bit is 1 sends no message and sets bit v of the pending array (pending word v/32, bit v%32) on the clock edge that samples it.
- R4: While the enable (control bit 15) is 0, no message is offered; requests still set their pending bits, and setting the enable sends them.
- R5: While the function mask (control bit 14) is 1, no message is offered for any vector, whatever the per-vector masks; clearing it sends every pending vector that is unmasked and enabled.
- R6: When a vector with its pending bit set becomes eligible, a message with that vector's table address and data is offered.
- R7: A pending bit is cleared only on the clock edge where its message is accepted (`msg_valid` and `msg_ready` both 1); until then it stays set.
- R8: When several vectors are eligible, the lowest-numbered one is offered first.
- R9: Once `msg_valid` is 1, it stays 1 with `msg_addr` and `msg_data` unchanged until the message is accepted.
- R10: The pending array is read-only; writes to its words have no effect.
- R11: Several requests on a vector that is already pending merge into one pending bit and produce one message.
- R12: Only control bits 15 (enable) and 14 (function mask) are stored; the other control bits read 0.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst | input | 1 | Synchronous active-high reset |
| irq_req | input | NUM_VEC | Per-vector request pulses |
| reg_wen | input | 1 | Register write strobe |
| reg_addr | input | AW | Register word address |
| reg_wdata | input | 32 | Register write data |
| reg_rdata | output | 32 | Register read data for `reg_addr` (combinational) |
| msg_valid | output | 1 | Message offered |
| msg_ready | input | 1 | Message accepted by downstream |
| msg_addr | output | 64 | Message address |
| msg_data | output | 32 | Message data |

## Verification
The hardest situation to reach is several vectors becoming eligible at the same moment while one of them has been requested more than once. To get there, the stimulus holds the function mask set and pulses several vectors, one of them three times. It also pulses a vector that stays individually masked. It then clears the function mask with the channel ready. The bench checks the delivery order, that the repeated vector produces a single message, and that only the individually masked vector's pending bit remains. Back-pressure is exercised separately by holding `msg_ready` low while a message is offered.

// File: rtl/msix_pkg.sv
package msix_pkg;

    localparam int CTRL_EN_BIT = 15;
    localparam int CTRL_FM_BIT = 14;

    typedef struct packed {
        logic [63:0] addr;
        logic [31:0] data;
    } msix_msg_t;

    typedef struct packed {
        logic enable;
        logic fmask;
    } msix_ctrl_t;

    typedef enum logic [1:0] {
        FLD_ADDR_LO = 2'd0,
        FLD_ADDR_HI = 2'd1,
        FLD_DATA    = 2'd2,
        FLD_VCTRL   = 2'd3
    } msix_field_e;

    function automatic logic [31:0] ctrl_to_word(msix_ctrl_t c);
        logic [31:0] w;
        w = '0;
        w[CTRL_EN_BIT] = c.enable;
        w[CTRL_FM_BIT] = c.fmask;
        return w;
    endfunction

    function automatic msix_ctrl_t word_to_ctrl(logic [31:0] w);
        msix_ctrl_t c;
        c.enable = w[CTRL_EN_BIT];
        c.fmask  = w[CTRL_FM_BIT];
        return c;
    endfunction

endpackage

// File: rtl/msix_regs.sv
module msix_regs
    import msix_pkg::*;
#(
    parameter int NUM_VEC   = 8,
    parameter int PBA_WORDS = 1,
    parameter int AW        = 6
) (
    input  logic                          clk,
    input  logic                          rst,
    input  logic                          wen,
    input  logic [AW-1:0]                 addr,
    input  logic [31:0]                   wdata,
    input  logic [NUM_VEC-1:0]            pend,
    output logic [31:0]                   rdata,
    output msix_msg_t [NUM_VEC-1:0]       tbl,
    output logic [NUM_VEC-1:0]            vmask,
    output msix_ctrl_t                    ctrl
);

    localparam int TBL_WORDS = 4 * NUM_VEC;
    localparam int CTRL_ADDR = TBL_WORDS + PBA_WORDS;
    localparam int VIW       = AW - 2;

    logic [VIW-1:0]    vec_idx;
    msix_field_e       field;
    logic              tbl_hit;
    logic              pba_hit;
    logic              ctrl_hit;
    logic [AW-1:0]     pba_word;
    logic [PBA_WORDS*32-1:0] pend_ext;

    assign vec_idx  = addr[AW-1:2];
    assign field    = msix_field_e'(addr[1:0]);
    assign tbl_hit  = (32'(addr) < 32'(TBL_WORDS));
    assign pba_hit  = (32'(addr) >= 32'(TBL_WORDS)) && (32'(addr) < 32'(CTRL_ADDR));
    assign ctrl_hit = (32'(addr) == 32'(CTRL_ADDR));
    assign pba_word = addr - AW'(TBL_WORDS);

    always_comb begin
        pend_ext = '0;
        pend_ext[NUM_VEC-1:0] = pend;
    end

    // Per-vector table storage
    for (genvar v = 0; v < NUM_VEC; v++) begin : g_vec
        logic sel;
        assign sel = wen && tbl_hit && (vec_idx == VIW'(v));
        always_ff @(posedge clk) begin
            if (rst) begin
                tbl[v]   <= '0;
                vmask[v] <= 1'b1;
            end else if (sel) begin
                case (field)
                    FLD_ADDR_LO: tbl[v].addr[31:0]  <= wdata;
                    FLD_ADDR_HI: tbl[v].addr[63:32] <= wdata;
                    FLD_DATA:    tbl[v].data        <= wdata;
                    FLD_VCTRL:   vmask[v]           <= wdata[0];
                    default:     ;
                endcase
            end
        end
    end

    // Message control word: enable and function mask only
    always_ff @(posedge clk) begin
        if (rst) begin
            ctrl <= '0;
        end else if (wen && ctrl_hit) begin
            ctrl <= word_to_ctrl(wdata);
        end
    end

    // Combinational read mux; pending array is read-only
    always_comb begin
        rdata = '0;
        if (tbl_hit) begin
            case (field)
                FLD_ADDR_LO: rdata = tbl[vec_idx].addr[31:0];
                FLD_ADDR_HI: rdata = tbl[vec_idx].addr[63:32];
                FLD_DATA:    rdata = tbl[vec_idx].data;
                FLD_VCTRL:   rdata = {31'd0, vmask[vec_idx]};
                default:     rdata = '0;
            endcase
        end else if (pba_hit) begin
            rdata = pend_ext[pba_word*32 +: 32];
        end else if (ctrl_hit) begin
            rdata = ctrl_to_word(ctrl);
        end
    end

endmodule

// File: rtl/msix_pending.sv
module msix_pending #(
    parameter int NUM_VEC = 8
) (
    input  logic               clk,
    input  logic               rst,
    input  logic [NUM_VEC-1:0] set_req,
    input  logic [NUM_VEC-1:0] clr_acc,
    input  logic [NUM_VEC-1:0] eligible,
    output logic [NUM_VEC-1:0] pend,
    output logic [NUM_VEC-1:0] cand
);

    // A new request wins over a clear in the same cycle; repeats merge.
    always_ff @(posedge clk) begin
        if (rst) begin
            pend <= '0;
        end else begin
            pend <= (pend & ~clr_acc) | set_req;
        end
    end

    assign cand = pend & eligible;

endmodule

// File: rtl/msix_arbiter.sv
module msix_arbiter
    import msix_pkg::*;
#(
    parameter int NUM_VEC = 8,
    parameter int SW      = 3
) (
    input  logic                    clk,
    input  logic                    rst,
    input  logic [NUM_VEC-1:0]      cand,
    input  msix_msg_t [NUM_VEC-1:0] tbl,
    input  logic                    msg_ready,
    output logic                    msg_valid,
    output msix_msg_t               msg_out,
    output logic [SW-1:0]           sel_idx,
    output logic [NUM_VEC-1:0]      acc_vec
);

    logic [SW-1:0] win;

    // Lowest index has priority
    always_comb begin
        win = '0;
        for (int i = NUM_VEC - 1; i >= 0; i--) begin
            if (cand[i]) win = SW'(i);
        end
    end

    always_ff @(posedge clk) begin
        if (rst) begin
            msg_valid <= 1'b0;
            sel_idx   <= '0;
            msg_out   <= '0;
        end else if (msg_valid) begin
            if (msg_ready) msg_valid <= 1'b0;
        end else if (|cand) begin
            msg_valid <= 1'b1;
            sel_idx   <= win;
            msg_out   <= tbl[win];
        end
    end

    always_comb begin
        acc_vec = '0;
        if (msg_valid && msg_ready) acc_vec[sel_idx] = 1'b1;
    end

endmodule

// File: rtl/msix_dispatch.sv
module msix_dispatch
    import msix_pkg::*;
#(
    parameter  int NUM_VEC   = 8,
    localparam int PBA_WORDS = (NUM_VEC + 31) / 32,
    localparam int AW        = $clog2(4 * NUM_VEC + PBA_WORDS + 1)
) (
    input  logic               clk,
    input  logic               rst,
    input  logic [NUM_VEC-1:0] irq_req,
    input  logic               reg_wen,
    input  logic [AW-1:0]      reg_addr,
    input  logic [31:0]        reg_wdata,
    output logic [31:0]        reg_rdata,
    output logic               msg_valid,
    input  logic               msg_ready,
    output logic [63:0]        msg_addr,
    output logic [31:0]        msg_data
);

    localparam int SW = (NUM_VEC > 1) ? $clog2(NUM_VEC) : 1;

    msix_msg_t [NUM_VEC-1:0] tbl;
    logic [NUM_VEC-1:0]      vmask;
    msix_ctrl_t              ctrl_q;
    logic [NUM_VEC-1:0]      pend_q;
    logic [NUM_VEC-1:0]      cand;
    logic [NUM_VEC-1:0]      eligible;
    logic [NUM_VEC-1:0]      acc_vec;
    logic [SW-1:0]           sel_idx;
    msix_msg_t               msg_out;

    // Central eligibility: any control or mask change replays pending bits
    assign eligible = {NUM_VEC{ctrl_q.enable & ~ctrl_q.fmask}} & ~vmask;

    msix_regs #(
        .NUM_VEC  (NUM_VEC),
        .PBA_WORDS(PBA_WORDS),
        .AW       (AW)
    ) u_regs (
        .clk  (clk),
        .rst  (rst),
        .wen  (reg_wen),
        .addr (reg_addr),
        .wdata(reg_wdata),
        .pend (pend_q),
        .rdata(reg_rdata),
        .tbl  (tbl),
        .vmask(vmask),
        .ctrl (ctrl_q)
    );

    msix_pending #(
        .NUM_VEC(NUM_VEC)
    ) u_pend (
        .clk     (clk),
        .rst     (rst),
        .set_req (irq_req),
        .clr_acc (acc_vec),
        .eligible(eligible),
        .pend    (pend_q),
        .cand    (cand)
    );

    msix_arbiter #(
        .NUM_VEC(NUM_VEC),
        .SW     (SW)
    ) u_arb (
        .clk      (clk),
        .rst      (rst),
        .cand     (cand),
        .tbl      (tbl),
        .msg_ready(msg_ready),
        .msg_valid(msg_valid),
        .msg_out  (msg_out),
        .sel_idx  (sel_idx),
        .acc_vec  (acc_vec)
    );

    assign msg_addr = msg_out.addr;
    assign msg_data = msg_out.data;

endmodule

// File: rtl/msix_dispatch_chk.sv
module msix_dispatch_chk #(
    parameter int NUM_VEC = 8,
    parameter int SW      = 3
) (
    input logic               clk,
    input logic               rst,
    input logic [NUM_VEC-1:0] irq_req,
    input logic               msg_valid,
    input logic               msg_ready,
    input logic [63:0]        msg_addr,
    input logic [31:0]        msg_data,
    input logic [NUM_VEC-1:0] pend,
    input logic [SW-1:0]      sel_idx,
    input logic               ctrl_en,
    input logic               ctrl_fmask
);

    logic [NUM_VEC-1:0] acc_mask;
    always_comb begin
        acc_mask = '0;
        if (msg_valid && msg_ready) acc_mask[sel_idx] = 1'b1;
    end

    assert_req_sets_pend_R3: assert property (@(posedge clk) disable iff (rst)
        (|irq_req) |=> ((pend & $past(irq_req)) == $past(irq_req)));

    // Covers R4 (enable) and R5 (function mask)
    assert_gate_blocks_R5: assert property (@(posedge clk) disable iff (rst)
        $rose(msg_valid) |-> $past(ctrl_en && !ctrl_fmask));

    assert_offer_is_pending_R6: assert property (@(posedge clk) disable iff (rst)
        msg_valid |-> pend[sel_idx]);

    assert_pend_kept_R7: assert property (@(posedge clk) disable iff (rst)
        1'b1 |=> ((pend & $past(pend & ~acc_mask)) == $past(pend & ~acc_mask)));

    assert_pend_cleared_R7: assert property (@(posedge clk) disable iff (rst)
        (msg_valid && msg_ready && !irq_req[sel_idx]) |=> !pend[$past(sel_idx)]);

    assert_hold_stable_R9: assert property (@(posedge clk) disable iff (rst)
        (msg_valid && !msg_ready) |=> (msg_valid && $stable(msg_addr) && $stable(msg_data)));

endmodule

bind msix_dispatch msix_dispatch_chk #(
    .NUM_VEC(NUM_VEC),
    .SW     (SW)
) u_chk (
    .clk       (clk),
    .rst       (rst),
    .irq_req   (irq_req),
    .msg_valid (msg_valid),
    .msg_ready (msg_ready),
    .msg_addr  (msg_addr),
    .msg_data  (msg_data),
    .pend      (pend_q),
    .sel_idx   (sel_idx),
    .ctrl_en   (ctrl_q.enable),
    .ctrl_fmask(ctrl_q.fmask)
);

// File: tb/msix_dispatch_test.sv
`timescale 1ns/1ps
module msix_dispatch_test;

    localparam int N  = 8;
    localparam int AW = 6;
    localparam logic [AW-1:0] PBA_A  = 6'd32;
    localparam logic [AW-1:0] CTRL_A = 6'd33;

    logic          clk = 1'b0;
    logic          rst = 1'b1;
    logic [N-1:0]  irq_req = '0;
    logic          reg_wen = 1'b0;
    logic [AW-1:0] reg_addr = '0;
    logic [31:0]   reg_wdata = '0;
    logic [31:0]   reg_rdata;
    logic          msg_valid;
    logic          msg_ready = 1'b1;
    logic [63:0]   msg_addr;
    logic [31:0]   msg_data;

    int checks = 0;
    int errors = 0;

    always #4 clk = ~clk;

    msix_dispatch #(.NUM_VEC(N)) uut (
        .clk(clk), .rst(rst), .irq_req(irq_req),
        .reg_wen(reg_wen), .reg_addr(reg_addr), .reg_wdata(reg_wdata),
        .reg_rdata(reg_rdata), .msg_valid(msg_valid), .msg_ready(msg_ready),
        .msg_addr(msg_addr), .msg_data(msg_data)
    );

    // {addr, write data, expected readback}
    localparam logic [69:0] REGV [8] = '{
        {6'd4,  32'hA000_1000, 32'hA000_1000},   // R2 addr low
        {6'd5,  32'h0000_0012, 32'h0000_0012},   // R2 addr high
        {6'd6,  32'hCAFE_0011, 32'hCAFE_0011},   // R2 data
        {6'd7,  32'hFFFF_FFFE, 32'h0000_0000},   // R2 mask bit only
        {6'd7,  32'hFFFF_FFFF, 32'h0000_0001},   // R2
        {6'd32, 32'h0000_00FF, 32'h0000_0000},   // R10 pending read-only
        {6'd33, 32'hFFFF_FFFF, 32'h0000_C000},   // R12 control bits
        {6'd28, 32'h0000_5555, 32'h0000_5555}    // R2 other vector
    };

    task automatic check(input bit ok, input string req, input logic [63:0] act, input logic [63:0] exp);
        checks++;
        if (!ok) begin
            errors++;
            $display("FAIL %s actual=%h expected=%h", req, act, exp);
        end
    endtask

    task automatic wr(input logic [AW-1:0] a, input logic [31:0] d);
        @(negedge clk);
        reg_wen = 1'b1; reg_addr = a; reg_wdata = d;
        @(negedge clk);
        reg_wen = 1'b0;
    endtask

    task automatic rd(input logic [AW-1:0] a, output logic [31:0] d);
        reg_addr = a;
        #1;
        d = reg_rdata;
    endtask

    task automatic pulse(input logic [N-1:0] m);
        @(negedge clk);
        irq_req = m;
        @(negedge clk);
        irq_req = '0;
    endtask

    task automatic do_reset();
        @(negedge clk);
        rst = 1'b1;
        repeat (2) @(negedge clk);
        rst = 1'b0;
    endtask

    task automatic expect_msg(input int v, input string req);
        int waited = 0;
        while (!msg_valid && waited < 20) begin
            @(negedge clk);
            waited++;
        end
        check(msg_valid, req, {63'd0, msg_valid}, 64'd1);
        check(msg_data == 32'h100 + v, req, {32'd0, msg_data}, 64'h100 + v);
        check(msg_addr == 64'h1000 + 16 * v, req, msg_addr, 64'h1000 + 16 * v);
        @(negedge clk);
    endtask

    task automatic expect_quiet(input int cycles, input string req);
        bit seen = 1'b0;
        for (int c = 0; c < cycles; c++) begin
            @(negedge clk);
            if (msg_valid) seen = 1'b1;
        end
        check(!seen, req, {63'd0, seen}, 64'd0);
    endtask

    initial begin : watchdog
        repeat (20000) @(posedge clk);
        errors++;
        checks++;
        $display("FAIL watchdog actual=timeout expected=finish");
        $display("Simulation finished: %0d checks, %0d errors", checks, errors);
        $finish;
    end

    initial begin : main
        logic [31:0] d;
        logic [63:0] a0;
        logic [31:0] d0;
        repeat (3) @(negedge clk);
        rst = 1'b0;

        // R1 reset state
        rd(6'd3, d);  check(d == 32'd1, "R1", {32'd0, d}, 64'd1);
        rd(6'd31, d); check(d == 32'd1, "R1", {32'd0, d}, 64'd1);
        rd(PBA_A, d); check(d == 32'd0, "R1", {32'd0, d}, 64'd0);
        rd(CTRL_A, d); check(d == 32'd0, "R1", {32'd0, d}, 64'd0);
        check(!msg_valid, "R1", {63'd0, msg_valid}, 64'd0);

        // Register vector table walk (R2, R10, R12)
        for (int i = 0; i < 8; i++) begin
            wr(REGV[i][69:64], REGV[i][63:32]);
            rd(REGV[i][69:64], d);
            check(d == REGV[i][31:0], "R2/R10/R12 table", {32'd0, d}, {32'd0, REGV[i][31:0]});
        end

        do_reset();
        for (int v = 0; v < N; v++) begin
            wr(AW'(4 * v),     32'h1000 + 16 * v);
            wr(AW'(4 * v + 1), 32'h0);
            wr(AW'(4 * v + 2), 32'h100 + v);
        end
        wr(6'd11, 32'd0);   // unmask vector 2
        wr(6'd23, 32'd0);   // unmask vector 5

        // R4: enable off blocks, request pends
        pulse(8'h04);
        expect_quiet(5, "R4");
        rd(PBA_A, d); check(d == 32'h04, "R4", {32'd0, d}, 64'h04);
        wr(CTRL_A, 32'h8000);
        expect_msg(2, "R4");
        rd(PBA_A, d); check(d == 32'h00, "R7", {32'd0, d}, 64'h00);

        // R3: masked vector pends; R6: unmasking sends
        pulse(8'h08);
        expect_quiet(5, "R3");
        rd(PBA_A, d); check(d == 32'h08, "R3", {32'd0, d}, 64'h08);
        wr(6'd15, 32'd0);
        expect_msg(3, "R6");

        // R9 / R7: back-pressure
        msg_ready = 1'b0;
        pulse(8'h20);
        for (int c = 0; c < 20 && !msg_valid; c++) @(negedge clk);
        a0 = msg_addr; d0 = msg_data;
        repeat (3) @(negedge clk);
        check(msg_valid && msg_addr == a0 && msg_data == d0 && d0 == 32'h105, "R9",
              {32'd0, msg_data}, 64'h105);
        rd(PBA_A, d); check(d == 32'h20, "R7 held", {32'd0, d}, 64'h20);
        msg_ready = 1'b1;
        @(negedge clk);
        check(!msg_valid, "R7", {63'd0, msg_valid}, 64'd0);
        rd(PBA_A, d); check(d == 32'h00, "R7 cleared", {32'd0, d}, 64'h00);

        // R5 / R8 / R11: function mask burst
        wr(CTRL_A, 32'hC000);
        pulse(8'h04); pulse(8'h04); pulse(8'h04);
        pulse(8'h20); pulse(8'h08); pulse(8'h40);
        expect_quiet(5, "R5");
        rd(PBA_A, d); check(d == 32'h6C, "R5/R11", {32'd0, d}, 64'h6C);
        wr(CTRL_A, 32'h8000);
        expect_msg(2, "R8");
        expect_msg(3, "R8");
        expect_msg(5, "R5");
        expect_quiet(10, "R11");
        rd(PBA_A, d); check(d == 32'h40, "R5 masked remains", {32'd0, d}, 64'h40);

        $display("Simulation finished: %0d checks, %0d errors", checks, errors);
        $finish;
    end

endmodule